// File: doc/BRIEF.md
# Valid-Ready Word Memory Target

This block is a memory slave for a simple processor bus. The bus carries one transfer at a time. The master raises a request strobe and holds the byte address, the write data and a 4-bit byte-enable mask stable until the target acknowledges. An all-zero mask means a read. A nonzero mask is a write that updates only the enabled bytes of the addressed 32-bit word. Storage is an internal array of words with a registered read port.

Because the read port is registered, a read normally needs one cycle to fetch the word. The master can remove that cycle with an early-read hint: a one-cycle pulse, plus an address, given in the cycle before the request. The target then starts the array read early, and the read can be acknowledged in the request's first cycle. A parameter adds a fixed number of extra wait cycles to every transfer. A write whose mask is not one of the eight allowed shapes (empty, full word, either half-word, or a single byte) is acknowledged with an error pulse and leaves the array untouched.

Top module: `wordmem_target`

## Requirements
- R1: A synchronous active-high reset clears the acknowledge, the error flag and any pending early-read hint. A read issued after reset without a new hint takes one wait cycle, even if a hint was pulsed during reset. Array contents are not cleared.
- R2: `req_rdy` is high only while `req_vld` is high, and it is high for exactly one cycle per transfer. It stays low during a hint cycle while no request is active.
- R3: A write with a legal mask updates byte lane b (data bits 8b+7..8b) exactly when mask bit b is 1, and the other lanes keep their value.
- R4: A write whose mask is outside the legal set is acknowledged with `strb_err` high in that same cycle, and the addressed word keeps its previous value.
- R5: The legal nonzero masks are 4'b1111, 4'b1100, 4'b0011, 4'b1000, 4'b0100, 4'b0010 and 4'b0001. These never raise `strb_err`. The mask 4'b0000 is a read and never raises it either.
- R6: With WAIT_STATES=0, a read that follows a hint at the same word index is acknowledged in its first cycle, with the word on `rsp_rdata` in that cycle.
- R7: With WAIT_STATES=0, a read with no preceding hint is acknowledged in its second cycle with correct data. A write is acknowledged in its first cycle.
- R8: With WAIT_STATES=W, no transfer is acknowledged before its (W+1)-th cycle. With W=2 every read and write, with or without a hint, completes in its third cycle.
- R9: The word index is `req_addr[AW+1:2]`. Address bits 1:0 and the bits above AW+1 have no effect.
- R10: A hint whose address names a different word from the following read gives no speed-up: the read takes the one-cycle fetch path and returns the requested word.
- R11: A hint given in the acknowledge cycle of a write to the same word is not honoured. The next read of that word takes one wait cycle and returns the newly written data. A hint for a different word in that cycle is honoured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Transfer request, held until acknowledged |
| req_addr | input | 32 | Byte address of the transfer |
| req_wdata | input | 32 | Write data |
| req_wstrb | input | 4 | Byte-lane enables; zero means read |
| ahead_rd | input | 1 | Early-read hint, one cycle before a read request |
| ahead_wr | input | 1 | Early-write hint; drops any pending pre-read |
| ahead_addr | input | 32 | Byte address that goes with the hint |
| req_rdy | output | 1 | Transfer acknowledge, one-cycle pulse |
| rsp_rdata | output | 32 | Read data, valid while `req_rdy` is high on a read |
| strb_err | output | 1 | Illegal write mask, pulses with `req_rdy` |

## Verification
The bench builds two copies side by side, both with AW=6 and hints enabled. One uses WAIT_STATES=0, which exposes the zero-wait hinted read, the one-cycle fetch path, and the hint issued during a same-cycle write acknowledge. The other uses WAIT_STATES=2, where the added wait cycles hide the fetch cycle, so hinted and unhinted reads should take equally long. All 16 mask values, address aliasing and a random mix of reads and writes are checked against a byte-lane reference model on both copies.

// File: rtl/wordmem_target.sv
module wordmem_target #(
  parameter int AW          = 6,
  parameter int WAIT_STATES = 0,
  parameter bit LA_ENABLE   = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_vld,
  input  logic [31:0] req_addr,
  input  logic [31:0] req_wdata,
  input  logic [3:0]  req_wstrb,
  input  logic        ahead_rd,
  input  logic        ahead_wr,
  input  logic [31:0] ahead_addr,
  output logic        req_rdy,
  output logic [31:0] rsp_rdata,
  output logic        strb_err
);
  localparam int DEPTH = 1 << AW;
  localparam int CW    = $clog2(WAIT_STATES + 2);

  logic [31:0]   mem [DEPTH];
  logic [31:0]   rd_q;
  logic          pre_q;
  logic [AW-1:0] pre_idx_q;
  logic [CW-1:0] cnt_q;

  wire [AW-1:0] idx    = req_addr[AW+1:2];
  wire [AW-1:0] la_idx = ahead_addr[AW+1:2];
  wire unused_bits = ^{req_addr[31:AW+2], req_addr[1:0], ahead_addr[31:AW+2], ahead_addr[1:0]};

  wire is_rd   = (req_wstrb == 4'b0000);
  wire legal   = req_wstrb inside {4'b0000, 4'b1111, 4'b1100, 4'b0011,
                                   4'b1000, 4'b0100, 4'b0010, 4'b0001};
  wire hit     = pre_q && (pre_idx_q == idx);
  wire wait_ok = (cnt_q >= CW'(WAIT_STATES));

  assign req_rdy   = req_vld && wait_ok && (!is_rd || hit);
  assign strb_err  = req_rdy && !is_rd && !legal;
  assign rsp_rdata = rd_q;

  wire do_wr   = req_rdy && !is_rd && legal;
  wire idle    = !req_vld || req_rdy;
  wire la_take = LA_ENABLE && ahead_rd && idle && !(do_wr && la_idx == idx);
  wire la_kill = ahead_wr && idle;
  wire fetch   = req_vld && is_rd && !hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      pre_q     <= 1'b0;
      pre_idx_q <= '0;
    end else begin
      if (idle)          cnt_q <= '0;
      else if (!wait_ok) cnt_q <= cnt_q + 1'b1;

      if (fetch) begin
        pre_q     <= 1'b1;
        pre_idx_q <= idx;
      end else if (la_take) begin
        pre_q     <= 1'b1;
        pre_idx_q <= la_idx;
      end else if (req_rdy || la_kill) begin
        pre_q     <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fetch)        rd_q <= mem[idx];
    else if (la_take) rd_q <= mem[la_idx];
    if (do_wr) begin
      for (int b = 0; b < 4; b++)
        if (req_wstrb[b]) mem[idx][8*b +: 8] <= req_wdata[8*b +: 8];
    end
  end
endmodule

module wordmem_target_chk #(
  parameter int AW          = 6,
  parameter int WAIT_STATES = 0,
  parameter bit LA_ENABLE   = 1'b1
) (
  input logic        clk,
  input logic        rst,
  input logic        req_vld,
  input logic [31:0] req_addr,
  input logic [3:0]  req_wstrb,
  input logic        ahead_rd,
  input logic [31:0] ahead_addr,
  input logic        req_rdy,
  input logic        strb_err
);
  logic [7:0] vcnt;
  always_ff @(posedge clk) begin
    if (rst || !req_vld || req_rdy) vcnt <= '0;
    else if (vcnt != 8'hFF)         vcnt <= vcnt + 1'b1;
  end

  // R2
  rdy_needs_vld_chk: assert property (@(posedge clk) disable iff (rst) req_rdy |-> req_vld);

  // R4
  err_with_ack_chk: assert property (@(posedge clk) disable iff (rst)
    strb_err |-> (req_rdy && req_wstrb != 4'b0000));

  // R5
  legal_no_err_chk: assert property (@(posedge clk) disable iff (rst)
    (req_wstrb inside {4'b0000, 4'b1111, 4'b1100, 4'b0011, 4'b1000, 4'b0100, 4'b0010, 4'b0001})
    |-> !strb_err);

  // R8
  wait_count_chk: assert property (@(posedge clk) disable iff (rst)
    req_rdy |-> (int'(vcnt) >= WAIT_STATES));

  // R1
  reset_drops_hint_chk: assert property (@(posedge clk)
    (rst && WAIT_STATES == 0) |=> !(req_rdy && req_wstrb == 4'b0000));

  // R7
  cold_read_waits_chk: assert property (@(posedge clk) disable iff (rst)
    (req_vld && !$past(req_vld) && !$past(ahead_rd) && req_wstrb == 4'b0000) |-> !req_rdy);

  // R6
  hinted_read_fast_chk: assert property (@(posedge clk) disable iff (rst)
    (LA_ENABLE && WAIT_STATES == 0 && ahead_rd && !req_vld) ##1
    (req_vld && req_wstrb == 4'b0000 && req_addr[AW+1:2] == $past(ahead_addr[AW+1:2]))
    |-> req_rdy);
endmodule

bind wordmem_target wordmem_target_chk #(
  .AW(AW), .WAIT_STATES(WAIT_STATES), .LA_ENABLE(LA_ENABLE)
) chk_i (
  .clk(clk), .rst(rst), .req_vld(req_vld), .req_addr(req_addr),
  .req_wstrb(req_wstrb), .ahead_rd(ahead_rd), .ahead_addr(ahead_addr),
  .req_rdy(req_rdy), .strb_err(strb_err)
);

// File: tb/wordmem_target_tb.sv
module wordmem_target_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0]       vld = '0, ard = '0, awr = '0, rdy, err;
  logic [1:0][31:0] addr = '0, wdata = '0, aaddr = '0, rdata;
  logic [1:0][3:0]  strb = '0;
  logic [31:0] mdl [2][DEPTH];
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wordmem_target #(.AW(AW), .WAIT_STATES(0), .LA_ENABLE(1'b1)) dut_i (
    .clk(clk), .rst(rst), .req_vld(vld[0]), .req_addr(addr[0]), .req_wdata(wdata[0]),
    .req_wstrb(strb[0]), .ahead_rd(ard[0]), .ahead_wr(awr[0]), .ahead_addr(aaddr[0]),
    .req_rdy(rdy[0]), .rsp_rdata(rdata[0]), .strb_err(err[0]));

  wordmem_target #(.AW(AW), .WAIT_STATES(2), .LA_ENABLE(1'b1)) dut_w (
    .clk(clk), .rst(rst), .req_vld(vld[1]), .req_addr(addr[1]), .req_wdata(wdata[1]),
    .req_wstrb(strb[1]), .ahead_rd(ard[1]), .ahead_wr(awr[1]), .ahead_addr(aaddr[1]),
    .req_rdy(rdy[1]), .rsp_rdata(rdata[1]), .strb_err(err[1]));

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit legal_mask(input logic [3:0] s);
    case (s)
      4'h0, 4'hF, 4'hC, 4'h3, 4'h8, 4'h4, 4'h2, 4'h1: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int exp_lat(input int sel, input bit is_rd, input bit hinted);
    if (sel == 1) return 2;
    return (is_rd && !hinted) ? 1 : 0;
  endfunction

  task automatic xfer(input int sel, input logic [31:0] a, input logic [31:0] d, input logic [3:0] s,
                      input bit hint, input logic [31:0] ha, input int lat_exp, input string tag);
    int lat = 0;
    int w = int'(a[AW+1:2]);
    logic [31:0] exp_word = mdl[sel][w];
    if (hint) begin
      @(negedge clk);
      ard[sel] = 1'b1; aaddr[sel] = ha;
      #(CLK_PERIOD/2 - 1);
      check(rdy[sel] == 1'b0, {tag, " R2 no ack in hint cycle"}, 32'(rdy[sel]), 0);
    end
    @(negedge clk);
    ard[sel] = 1'b0;
    vld[sel] = 1'b1; addr[sel] = a; wdata[sel] = d; strb[sel] = s;
    forever begin
      #(CLK_PERIOD/2 - 1);
      if (rdy[sel] || lat > 20) break;
      @(negedge clk);
      lat++;
    end
    check(rdy[sel] == 1'b1 && lat == lat_exp, {tag, " latency"}, 32'(lat), 32'(lat_exp));
    if (s == 4'h0) check(rdata[sel] == exp_word, {tag, " read data"}, rdata[sel], exp_word);
    check(err[sel] == !legal_mask(s), {tag, " R4 R5 error flag"}, 32'(err[sel]), 32'(!legal_mask(s)));
    if (s != 4'h0 && legal_mask(s))
      for (int b = 0; b < 4; b++) if (s[b]) mdl[sel][w][8*b +: 8] = d[8*b +: 8];
    @(negedge clk);
    vld[sel] = 1'b0; strb[sel] = '0;
    #(CLK_PERIOD/2 - 1);
    check(rdy[sel] == 1'b0, {tag, " R2 single pulse"}, 32'(rdy[sel]), 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    #(CLK_PERIOD/2 - 1);
    check(rdy == 2'b00 && err == 2'b00, "R1 outputs after reset", 32'({rdy, err}), 0);
    @(negedge clk);
    ard[0] = 1'b1; aaddr[0] = 32'h0; rst = 1'b1;
    @(negedge clk);
    ard[0] = 1'b0; rst = 1'b0;
    xfer(0, 32'h0, 0, 4'h0, 1'b0, 0, 1, "R1 hint dropped by reset");
  endtask

  task automatic t_fill();
    for (int sel = 0; sel < 2; sel++)
      for (int i = 0; i < DEPTH; i++)
        xfer(sel, 32'(i*4), 32'hA5000000 ^ 32'(i * 32'h01010101), 4'hF, 1'b0, 0,
             exp_lat(sel, 1'b0, 1'b0), "R3 fill");
  endtask

  task automatic t_strobes();
    for (int sel = 0; sel < 2; sel++)
      for (int s = 0; s < 16; s++) begin
        logic [31:0] a = 32'(8 + s) * 4;
        xfer(sel, a, 32'h11223344 + 32'(s), 4'(s), 1'b0, 0, exp_lat(sel, s == 0, 1'b0), "R3 R4 R5 mask");
        xfer(sel, a, 0, 4'h0, 1'b1, a, exp_lat(sel, 1'b1, 1'b1), "R3 R4 readback");
      end
  endtask

  task automatic t_hint();
    xfer(0, 32'h40, 0, 4'h0, 1'b1, 32'h40, 0, "R6 hinted read");
    xfer(0, 32'h44, 0, 4'h0, 1'b0, 0, 1, "R7 unhinted read");
    xfer(1, 32'h40, 0, 4'h0, 1'b1, 32'h40, 2, "R8 hinted read wait");
    xfer(1, 32'h44, 0, 4'h0, 1'b0, 0, 2, "R8 unhinted read wait");
    xfer(1, 32'h48, 32'hCAFE0001, 4'hF, 1'b0, 0, 2, "R8 write wait");
    xfer(0, 32'h50, 0, 4'h0, 1'b1, 32'h54, 1, "R10 hint mismatch");
  endtask

  task automatic t_alias();
    xfer(0, 32'h8000_0063, 32'hDEADBEEF, 4'hF, 1'b0, 0, 0, "R9 aliased write");
    xfer(0, 32'h60, 0, 4'h0, 1'b1, 32'h60, 0, "R9 base read");
    xfer(0, 32'h4000_0061, 0, 4'h0, 1'b0, 0, 1, "R9 aliased read");
  endtask

  task automatic t_b2b();
    @(negedge clk);
    vld[0] = 1'b1; addr[0] = 32'h70; wdata[0] = 32'h0BADF00D; strb[0] = 4'hF;
    ard[0] = 1'b1; aaddr[0] = 32'h70;
    #(CLK_PERIOD/2 - 1);
    check(rdy[0] == 1'b1, "R11 write ack", 32'(rdy[0]), 1);
    mdl[0][28] = 32'h0BADF00D;
    @(negedge clk);
    ard[0] = 1'b0; strb[0] = 4'h0;
    #(CLK_PERIOD/2 - 1);
    check(rdy[0] == 1'b0, "R11 same-word hint ignored", 32'(rdy[0]), 0);
    @(negedge clk);
    #(CLK_PERIOD/2 - 1);
    check(rdy[0] == 1'b1 && rdata[0] == 32'h0BADF00D, "R11 fresh data", rdata[0], 32'h0BADF00D);
    @(negedge clk);
    addr[0] = 32'h74; wdata[0] = 32'h12345678; strb[0] = 4'hF;
    ard[0] = 1'b1; aaddr[0] = 32'h78;
    #(CLK_PERIOD/2 - 1);
    check(rdy[0] == 1'b1, "R11 second write ack", 32'(rdy[0]), 1);
    mdl[0][29] = 32'h12345678;
    @(negedge clk);
    ard[0] = 1'b0; addr[0] = 32'h78; strb[0] = 4'h0;
    #(CLK_PERIOD/2 - 1);
    check(rdy[0] == 1'b1 && rdata[0] == mdl[0][30], "R11 other-word hint honoured", rdata[0], mdl[0][30]);
    @(negedge clk);
    vld[0] = 1'b0;
  endtask

  task automatic t_random();
    for (int n = 0; n < 300; n++) begin
      int sel = n % 2;
      logic [31:0] a = {$urandom} & 32'hFFFF_FFFF;
      logic [3:0] s = 4'($urandom);
      bit h = $urandom_range(0, 1) == 1;
      if ($urandom_range(0, 2) == 0) s = 4'h0;
      xfer(sel, a, $urandom, s, h, a, exp_lat(sel, s == 0, h), "R3 R4 R9 random");
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_fill();
    t_strobes();
    t_hint();
    t_alias();
    t_b2b();
    t_random();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule